// File: doc/BRIEF.md
# Zoned Thermal Frame Alarm

This block watches a stream of temperature readings from an 8x8 thermal array and raises a sticky alarm when a pixel runs hot. One pixel arrives per valid beat, carrying its index in row-major order. The block compares that pixel against a programmed threshold in one of two ways. In absolute mode it compares the raw reading. In differential mode it first subtracts a stored background reading for the same pixel. The field of view is cut into four quadrants, and each quadrant can be switched in or out of the check.

A one-cycle capture request arms the block. From the next frame start, it records a whole frame as the new background. The alarm and a per-quadrant hit record stay set until the alarm-clear input is pulsed. Mode, threshold and quadrant enables are taken at each frame start, so a setting that changes in the middle of a frame waits for the next one.

Top module: `thermal_zone_alarm`

## Requirements
- R1: A pixel's quadrant is {index[5], index[2]}: quadrant 0 is the top-left 4x4 block, quadrant 1 the top-right, quadrant 2 the bottom-left and quadrant 3 the bottom-right. Bit q of `zone_hit` belongs to quadrant q, and bit q of `cfg_zone_en` enables quadrant q.
- R2: A pixel whose quadrant enable is 0 never sets `alarm` or any bit of `zone_hit`.
- R3: In absolute mode (`cfg_diff_mode`=0), a pixel triggers when its reading is greater than or equal to `cfg_threshold`. Both values are 12-bit two's complement, 0.25 °C per LSB.
- R4: In differential mode (`cfg_diff_mode`=1), a pixel triggers when (reading − stored background for that index) is greater than or equal to the threshold. The difference is formed at 13 bits, so 2047 − (−2048) counts as 4095 and does not wrap.
- R5: `alarm` stays high until `alarm_clr` is high at a clock edge. If a triggering pixel is sampled at the same edge as `alarm_clr`, `alarm` stays high.
- R6: `zone_hit` collects the quadrants of all triggering pixels since the last clear. `alarm_clr` empties it, except for the quadrant of a pixel that triggers at the same edge.
- R7: Differential mode never triggers while `background_valid` is 0.
- R8: A `capture_req` pulse takes effect at the next index-0 beat, or at an index-0 beat in the same cycle. Beats 0 to 63 of that frame are then stored as the background. `background_valid` goes high at the edge that stores index 63, and stays high.
- R9: Mode, threshold and quadrant enables are sampled on the index-0 beat. A change in the middle of a frame has no effect until the next index-0 beat.
- R10: After reset, `alarm`, `zone_hit` and `background_valid` are 0. A triggering beat shows on `alarm` and `zone_hit` right after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid | input | 1 | A pixel is present this cycle |
| pix_index | input | 6 | Pixel index, row-major, 0 to 63 |
| pix_value | input | 12 | Pixel temperature, signed, 0.25 °C per LSB |
| cfg_diff_mode | input | 1 | 0 = absolute, 1 = background-subtracted |
| cfg_threshold | input | 12 | Trigger threshold, signed |
| cfg_zone_en | input | 4 | Per-quadrant enable |
| capture_req | input | 1 | Pulse to arm a background capture |
| alarm_clr | input | 1 | Pulse to clear the alarm and the hit record |
| alarm | output | 1 | Sticky alarm |
| zone_hit | output | 4 | Quadrants that triggered since the last clear |
| background_valid | output | 1 | A full background frame has been stored |

## Verification
The assertions check, on every cycle, properties that hold whatever the pixel data:
- the alarm is sticky;
- a clear on an idle cycle empties the outputs;
- a newly set hit bit always matches the quadrant of the pixel sampled just before it;
- differential mode stays silent without a background;
- once the background is valid, it stays valid.

Some results depend on actual pixel values, and only the bench's scenarios can show them:
- the greater-or-equal boundary in both modes;
- the 13-bit difference at the extreme values;
- a capture that starts exactly at the frame start;
- settings that change in the middle of a frame;
- a clear that collides with a trigger.

// File: rtl/thza_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the zoned thermal alarm.
// Assumes: the quadrant count is fixed at four by the index split.
package thza_pkg;
    localparam int NUM_ZONES = 4;

    typedef enum logic {
        MODE_ABS  = 1'b0,
        MODE_DIFF = 1'b1
    } cmp_mode_e;
endpackage

// File: rtl/thza_frame_ctrl.sv
`timescale 1ns/1ps
// Frame-level control.
// Latches the comparison settings on each index-0 beat and holds them for the
// rest of the frame. Runs the arm/capture sequence for the background store.
// Assumes: pixels of a frame arrive in index order, from 0 to the last index.
module thza_frame_ctrl
    import thza_pkg::*;
#(
    parameter int PIX_W = 12,
    parameter int IDX_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pix_valid,
    input  logic [IDX_W-1:0]        pix_index,
    input  cmp_mode_e               cfg_mode,
    input  logic signed [PIX_W-1:0] cfg_thr,
    input  logic [NUM_ZONES-1:0]    cfg_zen,
    input  logic                    capture_req,
    output cmp_mode_e               eff_mode,
    output logic signed [PIX_W-1:0] eff_thr,
    output logic [NUM_ZONES-1:0]    eff_zen,
    output logic                    bg_wr,
    output logic                    bg_valid
);
    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    cmp_mode_e               mode_q;
    logic signed [PIX_W-1:0] thr_q;
    logic [NUM_ZONES-1:0]    zen_q;
    logic                    armed_q, cap_q, bgv_q;
    logic                    frame_start, start_cap;

    // Decode the frame start and decide whether a capture begins on this beat.
    always_comb begin
        frame_start = pix_valid && (pix_index == '0);
        start_cap   = frame_start && (armed_q || capture_req);
        bg_wr       = pix_valid && (start_cap || cap_q);
        eff_mode    = frame_start ? cfg_mode : mode_q;
        eff_thr     = frame_start ? cfg_thr  : thr_q;
        eff_zen     = frame_start ? cfg_zen  : zen_q;
        bg_valid    = bgv_q;
    end

    // Hold the settings taken at the latest frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_ABS;
            thr_q  <= '0;
            zen_q  <= '0;
        end else if (frame_start) begin
            mode_q <= cfg_mode;
            thr_q  <= cfg_thr;
            zen_q  <= cfg_zen;
        end
    end

    // Track the arm and capture state, and mark the background valid after the last pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cap_q   <= 1'b0;
            bgv_q   <= 1'b0;
        end else begin
            if (start_cap)        armed_q <= 1'b0;
            else if (capture_req) armed_q <= 1'b1;

            if (bg_wr && pix_index == LAST_IDX) begin
                cap_q <= 1'b0;
                bgv_q <= 1'b1;
            end else if (start_cap) begin
                cap_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/thza_bg_store.sv
`timescale 1ns/1ps
// Background frame store.
// One register per pixel, written by index. The read is combinational, so a
// pixel that is being written in a cycle reads its previous value.
// Assumes: the contents mean nothing until the controller reports a full capture.
module thza_bg_store #(
    parameter int PIX_W = 12,
    parameter int IDX_W = 6
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        idx,
    input  logic signed [PIX_W-1:0] wr_data,
    output logic signed [PIX_W-1:0] rd_data
);
    localparam int NPIX = 1 << IDX_W;

    logic signed [PIX_W-1:0] mem [NPIX];

    for (genvar i = 0; i < NPIX; i++) begin : g_cell
        // Write the cell whose index is presented during a capture.
        always_ff @(posedge clk) begin
            if (wr_en && idx == IDX_W'(i)) mem[i] <= wr_data;
        end
    end

    // Read the background value of the current pixel.
    always_comb rd_data = mem[idx];
endmodule

// File: rtl/thza_pix_eval.sv
`timescale 1ns/1ps
// Per-pixel evaluator.
// Forms the comparison subject (the raw reading, or the reading minus the
// background) at PIX_W+1 bits and compares it with the threshold. Produces a
// one-hot hit for the pixel's quadrant.
// Assumes: the index is row-major, and the quadrant is {row MSB, column MSB}.
module thza_pix_eval
    import thza_pkg::*;
#(
    parameter int PIX_W = 12,
    parameter int IDX_W = 6,
    parameter int COL_W = 3
) (
    input  logic                    pix_valid,
    input  logic [IDX_W-1:0]        pix_index,
    input  logic signed [PIX_W-1:0] pix_value,
    input  logic signed [PIX_W-1:0] bg_value,
    input  logic                    bg_valid,
    input  cmp_mode_e               mode,
    input  logic signed [PIX_W-1:0] thr,
    input  logic [NUM_ZONES-1:0]    zen,
    output logic [NUM_ZONES-1:0]    hit
);
    logic [1:0]            zone;
    logic signed [PIX_W:0] rd_x, bg_x, thr_x, subject;
    logic                  over;

    // Extend the operands, subtract, and compare.
    always_comb begin
        zone    = {pix_index[IDX_W-1], pix_index[COL_W-1]};
        rd_x    = {pix_value[PIX_W-1], pix_value};
        bg_x    = {bg_value[PIX_W-1], bg_value};
        thr_x   = {thr[PIX_W-1], thr};
        subject = (mode == MODE_DIFF) ? (rd_x - bg_x) : rd_x;
        over    = pix_valid && (mode == MODE_ABS || bg_valid) && (subject >= thr_x);
    end

    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
        // Route the trigger to its quadrant when that quadrant is enabled.
        always_comb hit[z] = over && zen[z] && (zone == 2'(z));
    end
endmodule

// File: rtl/thza_alarm_latch.sv
`timescale 1ns/1ps
// Sticky alarm record.
// Collects quadrant hits until a clear. A hit in the clear cycle survives it.
module thza_alarm_latch
    import thza_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_ZONES-1:0] hit,
    input  logic                 clr,
    output logic [NUM_ZONES-1:0] zone_hit,
    output logic                 alarm
);
    logic [NUM_ZONES-1:0] zone_q;

    // Accumulate the hits, or restart from the current hits on a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   zone_q <= '0;
        else if (clr) zone_q <= hit;
        else          zone_q <= zone_q | hit;
    end

    // Drive the outputs from the record.
    always_comb begin
        zone_hit = zone_q;
        alarm    = |zone_q;
    end
endmodule

// File: rtl/thermal_zone_alarm.sv
`timescale 1ns/1ps
// Zoned thermal frame alarm, top level.
// Connects the frame control, the background store, the pixel evaluator and
// the alarm record.
// Assumes: ROWS and COLS are powers of two of at least 2, so that the quadrant
// bits fall directly out of the index.
module thermal_zone_alarm
    import thza_pkg::*;
#(
    parameter int PIX_W = 12,
    parameter int ROWS  = 8,
    parameter int COLS  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pix_valid,
    input  logic [$clog2(ROWS*COLS)-1:0] pix_index,
    input  logic [PIX_W-1:0]           pix_value,
    input  logic                       cfg_diff_mode,
    input  logic [PIX_W-1:0]           cfg_threshold,
    input  logic [NUM_ZONES-1:0]       cfg_zone_en,
    input  logic                       capture_req,
    input  logic                       alarm_clr,
    output logic                       alarm,
    output logic [NUM_ZONES-1:0]       zone_hit,
    output logic                       background_valid
);
    localparam int COL_W = $clog2(COLS);
    localparam int IDX_W = $clog2(ROWS*COLS);

    cmp_mode_e               eff_mode;
    logic signed [PIX_W-1:0] eff_thr, bg_value;
    logic [NUM_ZONES-1:0]    eff_zen, hit_vec;
    logic                    bg_wr;

    thza_frame_ctrl #(.PIX_W(PIX_W), .IDX_W(IDX_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_valid   (pix_valid),
        .pix_index   (pix_index),
        .cfg_mode    (cmp_mode_e'(cfg_diff_mode)),
        .cfg_thr     ($signed(cfg_threshold)),
        .cfg_zen     (cfg_zone_en),
        .capture_req (capture_req),
        .eff_mode    (eff_mode),
        .eff_thr     (eff_thr),
        .eff_zen     (eff_zen),
        .bg_wr       (bg_wr),
        .bg_valid    (background_valid)
    );

    thza_bg_store #(.PIX_W(PIX_W), .IDX_W(IDX_W)) u_bg (
        .clk     (clk),
        .wr_en   (bg_wr),
        .idx     (pix_index),
        .wr_data ($signed(pix_value)),
        .rd_data (bg_value)
    );

    thza_pix_eval #(.PIX_W(PIX_W), .IDX_W(IDX_W), .COL_W(COL_W)) u_eval (
        .pix_valid (pix_valid),
        .pix_index (pix_index),
        .pix_value ($signed(pix_value)),
        .bg_value  (bg_value),
        .bg_valid  (background_valid),
        .mode      (eff_mode),
        .thr       (eff_thr),
        .zen       (eff_zen),
        .hit       (hit_vec)
    );

    thza_alarm_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit_vec),
        .clr      (alarm_clr),
        .zone_hit (zone_hit),
        .alarm    (alarm)
    );
endmodule

// File: rtl/thza_checker.sv
`timescale 1ns/1ps
// Property checker for thermal_zone_alarm. It is bound into the top level
// below.
module thza_checker #(
    parameter int IDX_W = 6,
    parameter int COL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid,
    input logic [IDX_W-1:0] pix_index,
    input logic             alarm_clr,
    input logic             alarm,
    input logic [3:0]       zone_hit,
    input logic             background_valid,
    input logic             eval_diff,
    input logic [3:0]       hit_vec
);
    AST_ALARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        alarm && !alarm_clr |=> alarm); // R5

    AST_CLR_IDLE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_clr && !pix_valid |=> !alarm && zone_hit == 4'b0); // R6

    AST_NO_DIFF_WITHOUT_BG: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && eval_diff && !background_valid |-> hit_vec == 4'b0); // R7

    AST_BG_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        background_valid |=> background_valid); // R8

    AST_NEW_HIT_IN_PIXEL_ZONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((zone_hit & ~($past(alarm_clr) ? 4'b0 : $past(zone_hit))) != 4'b0) |->
        ($past(pix_valid) &&
         ((zone_hit & ~($past(alarm_clr) ? 4'b0 : $past(zone_hit)) &
           ~(4'b1 << {$past(pix_index[IDX_W-1]), $past(pix_index[COL_W-1])})) == 4'b0))); // R1

    AST_RISE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> $past(pix_valid)); // R10
endmodule

bind thermal_zone_alarm thza_checker #(.IDX_W(IDX_W), .COL_W(COL_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .pix_valid        (pix_valid),
    .pix_index        (pix_index),
    .alarm_clr        (alarm_clr),
    .alarm            (alarm),
    .zone_hit         (zone_hit),
    .background_valid (background_valid),
    .eval_diff        (eff_mode == thza_pkg::MODE_DIFF),
    .hit_vec          (hit_vec)
);

// File: tb/thermal_zone_alarm_bench.sv
`timescale 1ns/1ps
// Directed bench for thermal_zone_alarm. Each task runs one scenario and
// checks its own results.
module thermal_zone_alarm_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid = 1'b0;
    logic [5:0]  pix_index = '0;
    logic [11:0] pix_value = '0;
    logic        cfg_diff_mode = 1'b0;
    logic [11:0] cfg_threshold = '0;
    logic [3:0]  cfg_zone_en = '0;
    logic        capture_req = 1'b0;
    logic        alarm_clr = 1'b0;
    logic        alarm;
    logic [3:0]  zone_hit;
    logic        background_valid;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    thermal_zone_alarm u_thermal_zone_alarm (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_index(pix_index),
        .pix_value(pix_value), .cfg_diff_mode(cfg_diff_mode),
        .cfg_threshold(cfg_threshold), .cfg_zone_en(cfg_zone_en),
        .capture_req(capture_req), .alarm_clr(alarm_clr), .alarm(alarm),
        .zone_hit(zone_hit), .background_valid(background_valid)
    );

    function automatic int bg_of(int i);
        return (i == 63) ? -2048 : i * 4 - 100;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic beat(int idx, int val);
        pix_valid = 1'b1;
        pix_index = idx[5:0];
        pix_value = val[11:0];
        @(negedge clk);
    endtask

    task automatic idle(int n);
        pix_valid   = 1'b0;
        capture_req = 1'b0;
        alarm_clr   = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_alarm();
        alarm_clr = 1'b1;
        @(negedge clk);
        alarm_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 reset alarm", alarm, 0);
        check("R10 reset zone_hit", zone_hit, 0);
        check("R10 reset background_valid", background_valid, 0);
    endtask

    task automatic t_absolute();
        cfg_diff_mode = 1'b0; cfg_threshold = 12'd120; cfg_zone_en = 4'b1111;
        for (int i = 0; i < 64; i++) begin
            beat(i, (i == 9) ? 120 : (i == 13) ? 119 : 80);
            if (i == 8) check("R10 no alarm before hot beat", alarm, 0);
            if (i == 9) check("R10 alarm right after hot beat", alarm, 1);
        end
        idle(1);
        check("R3 R1 equal triggers, below does not", zone_hit, 4'b0001);
    endtask

    task automatic t_clear();
        clear_alarm();
        check("R5 clear drops alarm", alarm, 0);
        check("R6 clear empties zone_hit", zone_hit, 0);
    endtask

    task automatic t_zones();
        cfg_diff_mode = 1'b0; cfg_threshold = 12'd120; cfg_zone_en = 4'b1110;
        for (int i = 0; i < 64; i++) beat(i, (i == 0 || i == 32 || i == 63) ? 200 : 80);
        idle(1);
        check("R2 R1 disabled quadrant ignored", zone_hit, 4'b1100);
        check("R2 alarm from enabled quadrants", alarm, 1);
        clear_alarm();
    endtask

    task automatic t_diff_no_bg();
        cfg_diff_mode = 1'b1; cfg_threshold = 12'd0; cfg_zone_en = 4'b1111;
        for (int i = 0; i < 64; i++) beat(i, 2000);
        idle(1);
        check("R7 differential silent without background", alarm, 0);
    endtask

    task automatic t_capture();
        capture_req = 1'b1;
        @(negedge clk);
        capture_req = 1'b0;
        idle(2);
        cfg_diff_mode = 1'b0; cfg_zone_en = 4'b0000;
        for (int i = 0; i < 64; i++) begin
            beat(i, bg_of(i));
            if (i == 62) check("R8 not valid before last pixel", background_valid, 0);
            if (i == 63) check("R8 valid after last pixel", background_valid, 1);
        end
        idle(1);
        check("R2 capture frame with all quadrants off", alarm, 0);
    endtask

    task automatic t_diff();
        cfg_diff_mode = 1'b1; cfg_threshold = 12'd10; cfg_zone_en = 4'b1111;
        for (int i = 0; i < 64; i++) beat(i, bg_of(i) + ((i == 21) ? 10 : 9));
        idle(1);
        check("R4 difference at threshold triggers", zone_hit, 4'b0010);
        clear_alarm();
        cfg_threshold = 12'd2047;
        for (int i = 0; i < 64; i++) beat(i, (i == 63) ? 2047 : bg_of(i) + 9);
        idle(1);
        check("R4 13-bit difference no wrap", zone_hit, 4'b1000);
        clear_alarm();
        check("R8 background_valid stays", background_valid, 1);
    endtask

    task automatic t_midframe();
        cfg_diff_mode = 1'b0; cfg_threshold = 12'd2047; cfg_zone_en = 4'b1111;
        for (int i = 0; i < 64; i++) begin
            if (i == 30) cfg_threshold = 12'd0;
            beat(i, 100);
        end
        idle(1);
        check("R9 mid-frame threshold change ignored", alarm, 0);
        for (int i = 0; i < 64; i++) beat(i, 100);
        idle(1);
        check("R9 new threshold used from next frame", zone_hit, 4'b1111);
    endtask

    task automatic t_collide();
        cfg_diff_mode = 1'b0; cfg_threshold = 12'd120; cfg_zone_en = 4'b1111;
        alarm_clr = 1'b1;
        beat(0, 200);
        alarm_clr = 1'b0;
        check("R5 trigger wins over clear", alarm, 1);
        check("R6 clear keeps only the new quadrant", zone_hit, 4'b0001);
        for (int i = 1; i < 64; i++) beat(i, 80);
        idle(1);
        check("R6 record after collision frame", zone_hit, 4'b0001);
        clear_alarm();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_absolute();
        t_clear();
        t_zones();
        t_diff_no_bg();
        t_capture();
        t_diff();
        t_midframe();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule